// File: doc/BRIEF.md
# Segmented DAC Thermometer Front End

This block is the digital input stage of a current-steering converter that uses an 8+6 split. Every clock it accepts one 14-bit sample. The upper eight bits become a 255-line unary code, one line per unit current cell. The lower six bits are delayed so that they leave the block in the same cycle as the unary code that belongs to the same sample. Those six bits then drive the binary-weighted cells directly.

The unary code is not built from 255 separate magnitude comparators. The 256 output positions are treated as a 16-by-16 grid.
- The upper nibble of the unary field picks one row, called the boundary row.
- A row classifier marks every row below the boundary row as full, every row above it as empty, and the boundary row itself as fine.
- A 16-line fine encoder turns the lower nibble into the contents of the boundary row.
- One multiplexer per row then assembles the grid from three sources: all ones, all zeros, or the fine pattern.

A register stage sits between the row decision and the row multiplexers, and a second register stage sits on the output. This keeps the logic depth at each stage short at high sample rates.

Top module: `tenc_seg_frontend`

## Requirements
- R1: The input splits into two fields. Bits [13:6] form the unary field M and feed only `unary_o`. Bits [5:0] form the binary field and feed only `binary_o`.
- R2: Line k of `unary_o` (k = 0..254, bit k of the port) is 1 exactly when k < M. With M = 0 no line is set, and with M = 255 all 255 lines are set.
- R3: Group the lines into rows of 16, so that row r holds lines 16r to 16r+15 (row 15 has only 15 real lines). Every row r below M[7:4] is all ones, and every row r above M[7:4] is all zeros.
- R4: Row M[7:4] holds the fine pattern. Its lowest M[3:0] bits are 1 and the rest of the row is 0.
- R5: For any input, at most one row of `unary_o` is partly filled. When such a row exists, it is row M[7:4].
- R6: `unary_o` shows the result for a sample two rising clock edges after the edge that captured that sample. After only one edge it still shows the previous result.
- R7: `binary_o` equals the binary field of the sample captured two edges earlier. It changes on the same edge as the `unary_o` for that sample.
- R8: While `rst_n` is low, both outputs are zero. This takes effect at once, without waiting for a clock edge.
- R9: A new sample is accepted on every edge. A stream of back-to-back samples produces one matching output per cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 14 | Input sample: unary field in [13:6], binary field in [5:0] |
| unary_o | output | 255 | Thermometer lines for the unit cells, line 0 in bit 0 |
| binary_o | output | 6 | Binary field, delay-matched to `unary_o` |

## Verification
The bench builds the block with its default split: an 8-bit unary field arranged as a 4-bit row index over a 4-bit column value, and a 6-bit binary field. With these values all 16384 input codes can be streamed back to back in one run. That run reaches every boundary row paired with every fine value, both ends of the unary range, and every binary value against every unary value. Single-sample probes on a quiet input pin down the exact edge at which each output changes. A reset asserted in the middle of a stream shows that both outputs clear without a clock edge.

// File: rtl/tenc_pkg.sv
package tenc_pkg;
  // Source chosen for one row of the unary grid
  typedef enum logic [1:0] {
    ROW_ZERO = 2'd0,
    ROW_ONE  = 2'd1,
    ROW_FINE = 2'd2
  } row_kind_e;
endpackage

// File: rtl/tenc_row_classifier.sv
module tenc_row_classifier
  import tenc_pkg::*;
#(
  parameter int ROW_W = 4,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ROW_W-1:0]            row_sel_i,
  output row_kind_e [ROWS-1:0]        kind_o
);
  logic [ROWS-1:0] fine_flag;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ROW_W-1:0] RIDX = ROW_W'(r);
    always_comb begin
      if (RIDX < row_sel_i)       kind_o[r] = ROW_ONE;
      else if (RIDX == row_sel_i) kind_o[r] = ROW_FINE;
      else                        kind_o[r] = ROW_ZERO;
    end
    assign fine_flag[r] = (kind_o[r] == ROW_FINE);
  end

  // R5
  single_fine_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(fine_flag));

  // R3
  first_row_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o[0] == ROW_FINE) == (row_sel_i == '0));
endmodule

// File: rtl/tenc_fine_encoder.sv
module tenc_fine_encoder #(
  parameter int COL_W = 4,
  localparam int COLS = 1 << COL_W
) (
  input  logic [COL_W-1:0] val_i,
  output logic [COLS-1:0]  row_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [COL_W:0] CIDX = (COL_W+1)'(c);
    assign row_o[c] = (CIDX < {1'b0, val_i});
  end
endmodule

// File: rtl/tenc_row_mux.sv
module tenc_row_mux
  import tenc_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  row_kind_e [ROWS-1:0]  kind_i,
  input  logic [COLS-1:0]       fine_i,
  output logic [ROWS*COLS-1:0]  grid_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_comb begin
      unique case (kind_i[r])
        ROW_ONE:  grid_o[r*COLS +: COLS] = '1;
        ROW_FINE: grid_o[r*COLS +: COLS] = fine_i;
        default:  grid_o[r*COLS +: COLS] = '0;
      endcase
    end
  end
endmodule

// File: rtl/tenc_delay_line.sv
module tenc_delay_line #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_d [DEPTH];
  logic [W-1:0] stage_q [DEPTH];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/tenc_seg_frontend.sv
module tenc_seg_frontend
  import tenc_pkg::*;
#(
  parameter int MSB_W = 8,
  parameter int LSB_W = 6,
  localparam int CODE_W = MSB_W + LSB_W,
  localparam int LINES  = (1 << MSB_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  unary_o,
  output logic [LSB_W-1:0]  binary_o
);
  localparam int ROW_W    = MSB_W / 2;
  localparam int COL_W    = MSB_W - ROW_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int PIPE_LAT = 2;

  logic [MSB_W-1:0] msb_val;
  logic [ROW_W-1:0] row_sel;
  logic [COL_W-1:0] col_val;

  assign msb_val = code_i[CODE_W-1 -: MSB_W];
  assign row_sel = msb_val[MSB_W-1 -: ROW_W];
  assign col_val = msb_val[COL_W-1:0];

  // Stage 1: row decision and fine row
  row_kind_e [ROWS-1:0] kind_d, kind_q;
  logic [COLS-1:0]      fine_d, fine_q;

  tenc_row_classifier #(.ROW_W(ROW_W)) u_class (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_sel_i (row_sel),
    .kind_o    (kind_d)
  );

  tenc_fine_encoder #(.COL_W(COL_W)) u_fine (
    .val_i (col_val),
    .row_o (fine_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) kind_q[r] <= ROW_ZERO;
      fine_q <= '0;
    end else begin
      kind_q <= kind_d;
      fine_q <= fine_d;
    end
  end

  // Stage 2: row multiplexers and output register
  logic [ROWS*COLS-1:0] grid;
  logic [LINES-1:0]     unary_d, unary_q;

  tenc_row_mux #(.ROWS(ROWS), .COLS(COLS)) u_mux (
    .kind_i (kind_q),
    .fine_i (fine_q),
    .grid_o (grid)
  );

  always_comb unary_d = grid[LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unary_q <= '0;
    else        unary_q <= unary_d;
  end

  assign unary_o = unary_q;

  // Binary field delay matched to the two unary stages
  tenc_delay_line #(.W(LSB_W), .DEPTH(PIPE_LAT)) u_lsb_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (code_i[LSB_W-1:0]),
    .q_o   (binary_o)
  );

  // Assertion support: edges seen since reset, saturating at PIPE_LAT
  logic [1:0] prime_d, prime_q;
  logic       primed;

  always_comb prime_d = (prime_q == 2'(PIPE_LAT)) ? prime_q : prime_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prime_q <= '0;
    else        prime_q <= prime_d;
  end

  assign primed = (prime_q == 2'(PIPE_LAT));

  logic [ROWS*COLS-1:0] out_grid;
  assign out_grid = {1'b0, unary_q};

  // R2
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((unary_o >> 1) & ~unary_o) == '0);

  // R4
  top_cell_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grid[ROWS*COLS-1] == 1'b0);

  // R6
  unary_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ($countones(unary_o) == 32'($past(msb_val, 2))));

  // R7
  binary_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (binary_o == $past(code_i[LSB_W-1:0], 2)));

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    localparam logic [ROW_W-1:0] RIDX = ROW_W'(r);
    // R3
    row_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (RIDX < $past(row_sel, 2))) |-> (out_grid[r*COLS +: COLS] == '1));
    // R3
    row_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (RIDX > $past(row_sel, 2))) |-> (out_grid[r*COLS +: COLS] == '0));
    // R4
    row_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (RIDX == $past(row_sel, 2))) |->
      (out_grid[r*COLS +: COLS] == ((COLS'(1) << $past(col_val, 2)) - COLS'(1))));
  end
endmodule

// File: tb/sim_tenc_seg_frontend.sv
`timescale 1ns/1ps
module sim_tenc_seg_frontend;
  localparam int CODE_W = 14;
  localparam int LSB_W  = 6;
  localparam int LINES  = 255;
  localparam int NCODES = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic [LINES-1:0]  unary;
  logic [LSB_W-1:0]  binary;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tenc_seg_frontend u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_i   (code),
    .unary_o  (unary),
    .binary_o (binary)
  );

  function automatic logic [LINES-1:0] exp_unary(int m);
    logic [LINES-1:0] v;
    for (int k = 0; k < LINES; k++) v[k] = (k < m);
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Rows that are neither full nor empty; returns count and index of last one
  task automatic row_scan(input logic [LINES-1:0] u, output int partial, output int idx,
                          output bit rows_ok, input int m);
    logic [255:0] g;
    g = {1'b0, u};
    partial = 0; idx = -1; rows_ok = 1'b1;
    for (int r = 0; r < 16; r++) begin
      logic [15:0] row;
      row = g[r*16 +: 16];
      if (row != 16'h0000 && row != 16'hFFFF) begin partial++; idx = r; end
      if (r < m / 16 && row != 16'hFFFF) rows_ok = 1'b0;
      if (r > m / 16 && row != 16'h0000) rows_ok = 1'b0;
      if (r == m / 16 && row != 16'((32'd1 << (m % 16)) - 1)) rows_ok = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    code = 14'h3FFF;
    repeat (3) @(negedge clk);
    // R8
    check(unary == '0, "R8 unary in reset", 256'(unary), 256'(0));
    check(binary == '0, "R8 binary in reset", 256'(binary), 256'(0));
    code = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_latency;
    logic [CODE_W-1:0] s;
    s = {8'hA5, 6'h2B};
    code = '0;
    repeat (3) @(negedge clk);
    code = s;
    @(negedge clk);
    code = '0;
    // R6, R7: one edge later the old result still shows
    check(unary == '0, "R6 unary after one edge", 256'(unary), 256'(0));
    check(binary == '0, "R7 binary after one edge", 256'(binary), 256'(0));
    @(negedge clk);
    check(unary == exp_unary(8'hA5), "R6 unary after two edges", 256'(unary),
          256'(exp_unary(8'hA5)));
    check(binary == 6'h2B, "R7 binary after two edges", 256'(binary), 256'(6'h2B));
    @(negedge clk);
    check(unary == '0 && binary == '0, "R6 following zero sample", 256'(unary), 256'(0));
  endtask

  task automatic t_extremes;
    code = {8'h00, 6'h3F};
    repeat (2) @(negedge clk);
    // R2 lower end, R1 binary field isolated from unary
    check(unary == '0, "R2 M=0 no lines", 256'(unary), 256'(0));
    check(binary == 6'h3F, "R1 binary with M=0", 256'(binary), 256'(6'h3F));
    code = {8'hFF, 6'h00};
    repeat (2) @(negedge clk);
    check(unary == '1, "R2 M=255 all lines", 256'(unary), 256'({LINES{1'b1}}));
    check(binary == 6'h00, "R1 binary with M=255", 256'(binary), 256'(0));
  endtask

  task automatic t_rows;
    int p, ix;
    bit ok;
    int ms [4] = '{8'h37, 8'h40, 8'h0F, 8'hF1};
    foreach (ms[i]) begin
      code = {8'(ms[i]), 6'h15};
      repeat (2) @(negedge clk);
      row_scan(unary, p, ix, ok, ms[i]);
      // R3, R4
      check(ok, "R3/R4 row contents", 256'(unary), 256'(exp_unary(ms[i])));
    end
  endtask

  task automatic t_sweep;
    int p, ix;
    bit ok;
    for (int c = 0; c < NCODES + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int v, m;
        v = c - 2;
        m = v >> LSB_W;
        // R9 back-to-back, R2 exact lines, R1/R7 binary field
        check(unary == exp_unary(m), "R9/R2 sweep unary", 256'(unary), 256'(exp_unary(m)));
        check(binary == 6'(v), "R9/R7 sweep binary", 256'(binary), 256'(6'(v)));
        row_scan(unary, p, ix, ok, m);
        // R5
        check(p <= 1 && (p == 0 || ix == m / 16), "R5 single partial row",
              256'(ix), 256'(m / 16));
      end
      code = (c < NCODES) ? CODE_W'(c) : '0;
    end
  endtask

  task automatic t_reset_mid;
    code = {8'hC3, 6'h11};
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    // R8 immediate clear
    check(unary == '0, "R8 unary async clear", 256'(unary), 256'(0));
    check(binary == '0, "R8 binary async clear", 256'(binary), 256'(0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(unary == exp_unary(8'hC3), "R6 after reset release", 256'(unary),
          256'(exp_unary(8'hC3)));
  endtask

  initial begin
    t_reset();
    t_latency();
    t_extremes();
    t_rows();
    t_sweep();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule